// File: doc/BRIEF.md
# Two-Wire Program/Verify Port Sequencer

This block is the host side of a two-wire serial program/verify link to an EPROM-style device. A simple request port hands it an operation code and, for load operations, a 14-bit word. The sequencer then produces the serial clock and data waveforms. It serializes each 6-bit command and each framed data word least significant bit first. It holds the data line quiet for the required pauses, and it releases the data line while the device answers a read. For a read it collects the returned word and presents it with a one-cycle strobe.

The same request port also powers the device up and down in the proper order. It drives a reset/high-voltage enable output and a separate supply enable output. Every serial clock phase lasts a programmable number of system clocks. Every pause is a count of system clocks derived from the system frequency and a minimum gap in nanoseconds.

The controller is a single state machine with six states:
- `S_IDLE` waits for a request.
- `S_HV_UP` holds the reset output high through one gap before the supply is enabled.
- `S_CMD` shifts the 6 command bits.
- `S_MID_GAP` is the pause between a command and its data frame.
- `S_DATA` shifts the 16-cycle data frame.
- `S_TAIL_GAP` is the pause after every operation.

Transitions:
- IDLE→HV_UP on a power-up request.
- IDLE→TAIL_GAP on a power-down request.
- IDLE→CMD on any command request.
- HV_UP→TAIL_GAP when the gap expires.
- CMD→MID_GAP after the last command cycle when the command carries data.
- CMD→TAIL_GAP after the last command cycle when it does not.
- MID_GAP→DATA when the gap expires.
- DATA→TAIL_GAP after the stop cycle.
- TAIL_GAP→IDLE when the gap expires.

Top module: `serprog_host`

## Requirements
- R1: While and after reset: `pclk` low, `pdat_o` low, `pdat_oe` high, `hv_rst` low, `vdd_en` low, `busy` low, `rd_valid` low.
- R2: Request codes on `req_op`:
  - 0 = load configuration (command 0x00)
  - 1 = load data (0x02)
  - 2 = read data (0x04)
  - 3 = increment address (0x06)
  - 4 = begin programming (0x08)
  - 5 = end programming (0x0E)
  - 6 = power up
  - 7 = power down

  Each command goes out as exactly 6 `pclk` pulses, bit 0 on the first pulse.
- R3: Every `pclk` high phase and every low phase inside a frame lasts `HALF_DIV` system clocks. `pdat_o` changes only together with a rising `pclk` edge, so it is stable across each falling edge.
- R4: Between the last falling `pclk` edge of a command and the first rising edge of its data frame there are at least `GAP_CYC` system clocks.
- R5: For the two load operations, the data frame is 16 pulses. Pulse 1 carries 0 (start). Pulses 2–15 carry `req_wdata` bits 0..13. Pulse 16 carries 0 (stop).
- R6: For a read, `pdat_oe` is low for all 16 pulses of the data frame and high for the command pulses. `pdat_i` is sampled at the falling edge of pulses 2–15 into bits 0..13 of `rd_data`. `rd_valid` pulses for one cycle after the stop pulse.
- R7: Increment, begin programming and end programming send the command only, with no data frame.
- R8: `busy` rises in the cycle after a request is accepted and stays high until the trailing gap of at least `GAP_CYC` clocks has elapsed. A request presented while `busy` is high is ignored.
- R9: Power-up keeps `pclk` and `pdat_o` low and raises `hv_rst` first. `vdd_en` rises no earlier than `GAP_CYC` clocks later.
- R10: Power-down drives both `hv_rst` and `vdd_en` low, and `vdd_en` is never high while `hv_rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_op | input | 3 | Request code (see R2) |
| req_wdata | input | 14 | Word for load operations |
| busy | output | 1 | Operation in progress, requests ignored |
| rd_data | output | 14 | Word returned by a read |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| pclk | output | 1 | Serial clock to the device |
| pdat_o | output | 1 | Serial data driven to the device |
| pdat_oe | output | 1 | Output enable for the data line |
| pdat_i | input | 1 | Serial data returned by the device |
| hv_rst | output | 1 | Reset/high-voltage enable |
| vdd_en | output | 1 | Device supply enable |

## Verification
The bench builds the block with `HALF_DIV` = 2, `CLK_MHZ` = 200 and `GAP_NS` = 40, which gives a gap of 8 system clocks. Each serial pulse then spans four clocks, and a full read operation with all its gaps completes in about a hundred cycles. That makes every command code, both load paths, read capture with a device model, back-to-back pauses and request rejection cheap to cover directly. The small gap also keeps the pause measurements exact enough to show an off-by-one in the gap counter.

// File: rtl/serprog_pkg.sv
package serprog_pkg;

    localparam int CMD_W = 6;

    typedef enum logic [2:0] {
        OP_LOAD_CFG  = 3'd0,
        OP_LOAD_DATA = 3'd1,
        OP_READ_DATA = 3'd2,
        OP_INC_ADDR  = 3'd3,
        OP_BEGIN_PGM = 3'd4,
        OP_END_PGM   = 3'd5,
        OP_POWER_UP  = 3'd6,
        OP_POWER_DN  = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HV_UP,
        S_CMD,
        S_MID_GAP,
        S_DATA,
        S_TAIL_GAP
    } state_e;

    function automatic logic [CMD_W-1:0] cmd_code(op_e op);
        unique case (op)
            OP_LOAD_CFG:  return 6'h00;
            OP_LOAD_DATA: return 6'h02;
            OP_READ_DATA: return 6'h04;
            OP_INC_ADDR:  return 6'h06;
            OP_BEGIN_PGM: return 6'h08;
            OP_END_PGM:   return 6'h0E;
            default:      return 6'h00;
        endcase
    endfunction

    function automatic logic has_frame(op_e op);
        return (op == OP_LOAD_CFG) || (op == OP_LOAD_DATA) || (op == OP_READ_DATA);
    endfunction

endpackage

// File: rtl/serprog_halfdiv.sv
module serprog_halfdiv #(
    parameter int HALF_DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/serprog_gap_timer.sv
module serprog_gap_timer #(
    parameter int GAP_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

    logic [CW-1:0] cnt;

    assign done = run && (cnt == CW'(GAP_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || done)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/serprog_shifter.sv
module serprog_shifter #(
    parameter int FRAME_BITS = 16,
    parameter int WORD_BITS  = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] load_val,
    input  logic                  shift,
    input  logic                  sample,
    input  logic                  rx_bit,
    output logic                  tx_bit,
    output logic [WORD_BITS-1:0]  rx_word
);
    logic [FRAME_BITS-1:0] tx_q;

    assign tx_bit = tx_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tx_q <= '0;
        else if (load)
            tx_q <= load_val;
        else if (shift)
            tx_q <= {1'b0, tx_q[FRAME_BITS-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rx_word <= '0;
        else if (sample)
            rx_word <= {rx_bit, rx_word[WORD_BITS-1:1]};
    end
endmodule

// File: rtl/serprog_host.sv
module serprog_host
    import serprog_pkg::*;
#(
    parameter int HALF_DIV  = 20,
    parameter int CLK_MHZ   = 200,
    parameter int GAP_NS    = 1000,
    parameter int WORD_BITS = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [2:0]           req_op,
    input  logic [WORD_BITS-1:0] req_wdata,
    output logic                 busy,
    output logic [WORD_BITS-1:0] rd_data,
    output logic                 rd_valid,
    output logic                 pclk,
    output logic                 pdat_o,
    output logic                 pdat_oe,
    input  logic                 pdat_i,
    output logic                 hv_rst,
    output logic                 vdd_en
);
    localparam int GAP_CYC    = (CLK_MHZ * GAP_NS + 999) / 1000;
    localparam int FRAME_BITS = WORD_BITS + 2;
    localparam int BCW        = $clog2(FRAME_BITS);

    state_e               state, state_nx;
    op_e                  op_q;
    logic [WORD_BITS-1:0] wdata_q;
    logic                 phase_lo, phase_nx;
    logic [BCW-1:0]       bit_cnt, bit_nx;
    logic                 tick, gap_done, shifting, gap_run;
    logic                 rise_next, fall_now, last_bit, accept;
    logic                 tx_bit, rx_sample;
    logic                 ld_cmd, ld_frame;
    logic [FRAME_BITS-1:0] ld_val;
    logic [WORD_BITS-1:0] rx_word;

    assign shifting  = (state == S_CMD) || (state == S_DATA);
    assign gap_run   = (state == S_HV_UP) || (state == S_MID_GAP) || (state == S_TAIL_GAP);
    assign rise_next = tick && phase_lo;
    assign fall_now  = tick && !phase_lo;
    assign accept    = (state == S_IDLE) && req_valid;
    assign last_bit  = (state == S_CMD) ? (bit_cnt == BCW'(CMD_W - 1))
                                        : (bit_cnt == BCW'(FRAME_BITS - 1));

    serprog_halfdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .run(shifting), .tick(tick)
    );

    serprog_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk(clk), .rst_n(rst_n), .run(gap_run), .done(gap_done)
    );

    assign ld_cmd    = accept && (op_e'(req_op) != OP_POWER_UP) && (op_e'(req_op) != OP_POWER_DN);
    assign ld_frame  = (state == S_MID_GAP) && gap_done;
    assign ld_val    = ld_cmd ? FRAME_BITS'(cmd_code(op_e'(req_op)))
                              : {1'b0, wdata_q, 1'b0};
    assign rx_sample = fall_now && (state == S_DATA) && (bit_cnt != '0)
                       && (bit_cnt != BCW'(FRAME_BITS - 1));

    serprog_shifter #(.FRAME_BITS(FRAME_BITS), .WORD_BITS(WORD_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .load(ld_cmd || ld_frame), .load_val(ld_val),
        .shift(rise_next && !last_bit),
        .sample(rx_sample), .rx_bit(pdat_i),
        .tx_bit(tx_bit), .rx_word(rx_word)
    );

    // next-state, phase and bit position
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (req_valid) begin
                    if (op_e'(req_op) == OP_POWER_UP)      state_nx = S_HV_UP;
                    else if (op_e'(req_op) == OP_POWER_DN) state_nx = S_TAIL_GAP;
                    else                                   state_nx = S_CMD;
                end
            end
            S_HV_UP:    if (gap_done) state_nx = S_TAIL_GAP;
            S_CMD:      if (rise_next && last_bit)
                            state_nx = has_frame(op_q) ? S_MID_GAP : S_TAIL_GAP;
            S_MID_GAP:  if (gap_done) state_nx = S_DATA;
            S_DATA:     if (rise_next && last_bit) state_nx = S_TAIL_GAP;
            S_TAIL_GAP: if (gap_done) state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase

        phase_nx = (shifting && tick) ? !phase_lo : phase_lo;
        if (state_nx != state || !shifting)
            phase_nx = 1'b0;

        bit_nx = bit_cnt;
        if (rise_next)
            bit_nx = last_bit ? '0 : bit_cnt + 1'b1;
        if (!shifting)
            bit_nx = '0;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            op_q     <= OP_LOAD_CFG;
            wdata_q  <= '0;
            phase_lo <= 1'b0;
            bit_cnt  <= '0;
        end else begin
            state    <= state_nx;
            phase_lo <= phase_nx;
            bit_cnt  <= bit_nx;
            if (accept) begin
                op_q    <= op_e'(req_op);
                wdata_q <= req_wdata;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pclk     <= 1'b0;
            hv_rst   <= 1'b0;
            vdd_en   <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            pclk     <= ((state_nx == S_CMD) || (state_nx == S_DATA)) && !phase_nx;
            rd_valid <= 1'b0;
            if (accept && op_e'(req_op) == OP_POWER_UP)
                hv_rst <= 1'b1;
            if (state == S_HV_UP && gap_done)
                vdd_en <= 1'b1;
            if (accept && op_e'(req_op) == OP_POWER_DN) begin
                hv_rst <= 1'b0;
                vdd_en <= 1'b0;
            end
            if (state == S_DATA && rise_next && last_bit && op_q == OP_READ_DATA) begin
                rd_valid <= 1'b1;
                rd_data  <= rx_word;
            end
        end
    end

    assign busy    = (state != S_IDLE);
    assign pdat_o  = shifting && tx_bit;
    assign pdat_oe = !((state == S_DATA) && (op_q == OP_READ_DATA));

endmodule

// File: rtl/serprog_host_chk.sv
module serprog_host_chk (
    input logic clk,
    input logic rst_n,
    input logic pclk,
    input logic pdat_o,
    input logic pdat_oe,
    input logic busy,
    input logic hv_rst,
    input logic vdd_en,
    input logic rd_valid
);
    // R3
    pdat_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pclk && $past(pclk)) |-> $stable(pdat_o));

    // R3
    pdat_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pclk) |-> $stable(pdat_o));

    // R6
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(!pdat_oe));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pclk && pdat_oe && !rd_valid));

    // R9
    supply_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vdd_en) |-> (hv_rst && $stable(hv_rst)));

    // R10
    supply_needs_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_en |-> hv_rst);
endmodule

bind serprog_host serprog_host_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pclk(pclk), .pdat_o(pdat_o), .pdat_oe(pdat_oe),
    .busy(busy), .hv_rst(hv_rst), .vdd_en(vdd_en), .rd_valid(rd_valid)
);

// File: tb/serprog_host_test.sv
`timescale 1ns/1ps
module serprog_host_test;
    localparam int HALF = 2;
    localparam int GAP  = 8;
    localparam real TCK = 5.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [13:0] req_wdata = '0;
    logic        busy, rd_valid, pclk, pdat_o, pdat_oe, hv_rst, vdd_en;
    logic [13:0] rd_data;
    logic        pdat_i = 1'b0;

    int checks = 0;
    int errors = 0;

    serprog_host #(.HALF_DIV(HALF), .CLK_MHZ(200), .GAP_NS(40)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_wdata(req_wdata), .busy(busy), .rd_data(rd_data), .rd_valid(rd_valid),
        .pclk(pclk), .pdat_o(pdat_o), .pdat_oe(pdat_oe), .pdat_i(pdat_i),
        .hv_rst(hv_rst), .vdd_en(vdd_en)
    );

    always #2.5 clk = ~clk;

    // device-side log
    real  rise_t [64];
    real  fall_t [64];
    logic fall_bit [64];
    logic fall_oe [64];
    int   nrise = 0;
    int   nfall = 0;
    logic [13:0] dev_word = '0;
    int   nvalid = 0;
    logic [13:0] got_word = '0;
    real  hv_t = 0.0;
    real  vdd_t = 0.0;
    logic hv_pins_ok = 1'b0;

    always @(posedge pclk) begin
        if (nrise < 64) rise_t[nrise] = $realtime;
        if (nrise >= 7 && nrise <= 20) pdat_i = dev_word[nrise-7];
        else pdat_i = 1'b0;
        nrise++;
    end

    always @(negedge pclk) begin
        if (nfall < 64) begin
            fall_t[nfall]   = $realtime;
            fall_bit[nfall] = pdat_o;
            fall_oe[nfall]  = pdat_oe;
        end
        nfall++;
    end

    always @(negedge clk) if (rd_valid) begin
        nvalid++;
        got_word = rd_data;
    end

    always @(posedge hv_rst) begin
        hv_t = $realtime;
        hv_pins_ok = !pclk && !pdat_o && pdat_oe;
    end
    always @(posedge vdd_en) vdd_t = $realtime;

    function automatic int clks(real a, real b);
        return $rtoi((b - a) / TCK + 0.5);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        nrise = 0; nfall = 0; nvalid = 0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [13:0] w);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_wdata = w;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic check_cmd(input string req, input logic [5:0] code);
        for (int i = 0; i < 6; i++)
            chk(fall_bit[i] == code[i] && fall_oe[i], req, $sformatf("cmd bit %0d", i),
                int'(fall_bit[i]), int'(code[i]));
    endtask

    task automatic check_timing(input string req, input int pulses);
        int bad = 0;
        for (int i = 0; i < pulses; i++) begin
            if (clks(rise_t[i], fall_t[i]) != HALF) bad++;
            if (i + 1 < pulses && i != 5 && clks(fall_t[i], rise_t[i+1]) != HALF) bad++;
        end
        chk(bad == 0, req, "half-phase length violations", bad, 0);
    endtask

    // R1
    task automatic t_reset();
        chk(!pclk && !pdat_o && pdat_oe && !hv_rst && !vdd_en && !busy && !rd_valid,
            "R1", "reset outputs", {pclk, pdat_o, pdat_oe, hv_rst, vdd_en, busy, rd_valid},
            7'b0010000);
    endtask

    // R9
    task automatic t_power_up();
        clear_log();
        issue(3'd6, '0);
        wait_idle();
        chk(hv_rst && vdd_en, "R9", "hv/vdd after power-up", {hv_rst, vdd_en}, 2'b11);
        chk(hv_pins_ok, "R9", "pins low at hv rise", int'(hv_pins_ok), 1);
        chk(clks(hv_t, vdd_t) >= GAP, "R9", "hv to vdd clocks", clks(hv_t, vdd_t), GAP);
        chk(nrise == 0, "R9", "no clock pulses", nrise, 0);
    endtask

    // R5 R4 R3
    task automatic t_load(input logic [2:0] op, input logic [5:0] code, input logic [13:0] w);
        clear_log();
        issue(op, w);
        wait_idle();
        chk(nfall == 22, "R5", "pulse count", nfall, 22);
        check_cmd("R2", code);
        chk(fall_bit[6] == 1'b0, "R5", "start bit", int'(fall_bit[6]), 0);
        for (int i = 0; i < 14; i++)
            chk(fall_bit[7+i] == w[i] && fall_oe[7+i], "R5", $sformatf("data bit %0d", i),
                int'(fall_bit[7+i]), int'(w[i]));
        chk(fall_bit[21] == 1'b0, "R5", "stop bit", int'(fall_bit[21]), 0);
        chk(clks(fall_t[5], rise_t[6]) >= GAP, "R4", "cmd-to-data clocks",
            clks(fall_t[5], rise_t[6]), GAP);
        check_timing("R3", 22);
    endtask

    // R6
    task automatic t_read(input logic [13:0] w);
        int oe_bad = 0;
        clear_log();
        dev_word = w;
        issue(3'd2, '0);
        wait_idle();
        chk(nfall == 22, "R6", "pulse count", nfall, 22);
        check_cmd("R2", 6'h04);
        for (int i = 6; i < 22; i++) if (fall_oe[i]) oe_bad++;
        chk(oe_bad == 0, "R6", "frame pulses with oe high", oe_bad, 0);
        chk(nvalid == 1, "R6", "rd_valid pulses", nvalid, 1);
        chk(got_word == w, "R6", "read word", int'(got_word), int'(w));
    endtask

    // R7
    task automatic t_short(input logic [2:0] op, input logic [5:0] code);
        clear_log();
        issue(op, 14'h3FFF);
        wait_idle();
        chk(nfall == 6, "R7", "pulse count", nfall, 6);
        check_cmd("R2", code);
        check_timing("R3", 6);
    endtask

    // R8
    task automatic t_busy();
        real last_fall;
        clear_log();
        issue(3'd3, '0);
        chk(busy, "R8", "busy after accept", int'(busy), 1);
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd1; req_wdata = 14'h1555;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        repeat (40) @(negedge clk);
        chk(nfall == 6, "R8", "pulses with ignored request", nfall, 6);
        chk(!busy, "R8", "busy low when done", int'(busy), 0);
        // back-to-back commands
        clear_log();
        issue(3'd4, '0);
        wait_idle();
        last_fall = fall_t[5];
        clear_log();
        issue(3'd5, '0);
        wait_idle();
        chk(clks(last_fall, rise_t[0]) >= GAP, "R8", "gap between commands",
            clks(last_fall, rise_t[0]), GAP);
    endtask

    // R10
    task automatic t_power_down();
        issue(3'd7, '0);
        wait_idle();
        chk(!hv_rst && !vdd_en, "R10", "hv/vdd after power-down", {hv_rst, vdd_en}, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_power_up();
        t_load(3'd1, 6'h02, 14'h2A5B);
        t_load(3'd0, 6'h00, 14'h1234);
        t_load(3'd1, 6'h02, 14'h3FFF);
        t_read(14'h35A7);
        t_read(14'h0001);
        t_short(3'd3, 6'h06);
        t_short(3'd4, 6'h08);
        t_short(3'd5, 6'h0E);
        t_busy();
        t_power_down();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(TCK * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule